// File: doc/BRIEF.md
# Pointer-Addressed Accumulator File

This block holds the working accumulators of a small processor core together with the status flags that describe them. It is built with either 8 or 16 entries, and each entry is 8 or 16 bits wide. Any entry can be read and written by index. One entry at a time is the active accumulator. A pointer register selects it. ALU results always land in that entry, and the zero and sign flags always describe it.

A control register sets how the pointer moves. Software can clear it to zero in one write. It can also make the pointer step up or down by one after each access to the active accumulator. The step wraps inside an aligned group of 2, 4 or 8 entries, or inside the whole file, so that software can walk a ring of accumulators without reloading the pointer. The ALU itself is outside the block. The block receives its result, its carry and overflow outputs, and the operand of a compare, and it returns the carry flag that an add-with-carry needs.

Flag vector layout on `flags_o`: [0] carry, [1] zero, [2] sign, [3] equal, [4] overflow, [5] general flag 0, [6] general flag 1.

Top module: `acc_file_top`

## Requirements
- R1: `dir_rdata_o` shows the entry selected by `dir_idx_i` in the same cycle. `dir_we_i` writes `dir_wdata_i` to that entry at the clock edge, unless an ALU or active-port write happens in the same cycle.
- R2: `act_rdata_o` shows the entry selected by `ptr_o` in the same cycle. `act_we_i` writes `act_wdata_i` to that entry at the edge.
- R3: `alu_we_i` writes `alu_result_i` to the active entry. In the same cycle it takes precedence over `act_we_i`, and `act_we_i` takes precedence over `dir_we_i`.
- R4: `ptr_we_i` loads `ptr_wdata_i` into the pointer at the edge. This load wins over a clear and over an auto-step in the same cycle.
- R5: A control write (`ctl_we_i`) does three things:
  - If `ctl_wdata_i[0]` is 1, the pointer is cleared to zero.
  - `ctl_wdata_i[2:1]` sets the step mode: 01 steps up, 10 steps down, and 00 or 11 means no step.
  - `ctl_wdata_i[4:3]` sets the wrap group: 00 is 2 entries, 01 is 4, 10 is 8, and 11 is the whole file.
  
  `ctl_o` reads back `{group, step}`. A new mode applies from the next cycle onward.
- R6: In a cycle with `act_re_i`, `act_we_i` or `alu_we_i` while stepping is enabled, the pointer moves by one within its aligned group: the low bits wrap and the upper bits are kept. With no access, load or clear, the pointer holds its value.
- R7: Zero (`flags_o[1]`) is 1 exactly when the active entry is zero. Sign (`flags_o[2]`) equals the active entry's top bit. Both flags follow writes and pointer moves.
- R8: `cmp_valid_i` sets equal (`flags_o[3]`) to the result of comparing the active entry, as it stood before the edge, with `cmp_src_i`.
- R9: Carry (`flags_o[0]`) and overflow (`flags_o[4]`) change only in two cases. An ALU write with `alu_arith_i` set loads them from `alu_carry_i` and `alu_ovf_i`. A status write also changes them.
- R10: `psf_we_i` loads `psf_wdata_i` into the software-writable flags: [0] carry, [1] equal, [2] overflow, [3] general flag 0, [4] general flag 1. This load overrides hardware updates in the same cycle. The general flags change in no other way.
- R11: After reset, every entry is zero, the pointer and control are zero, zero is 1, and all other flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_idx_i | input | PW | Index for the direct port |
| dir_we_i | input | 1 | Direct write enable |
| dir_wdata_i | input | ACC_W | Direct write data |
| dir_rdata_o | output | ACC_W | Direct read data |
| act_re_i | input | 1 | Active accumulator read access |
| act_we_i | input | 1 | Active accumulator write enable |
| act_wdata_i | input | ACC_W | Active write data |
| act_rdata_o | output | ACC_W | Active accumulator value |
| ptr_we_i | input | 1 | Pointer load |
| ptr_wdata_i | input | PW | Pointer load value |
| ptr_o | output | PW | Current pointer |
| ctl_we_i | input | 1 | Control write |
| ctl_wdata_i | input | 5 | Clear bit, step mode, wrap group |
| ctl_o | output | 4 | Held control `{group, step}` |
| alu_we_i | input | 1 | ALU result write |
| alu_arith_i | input | 1 | ALU operation is arithmetic |
| alu_result_i | input | ACC_W | ALU result |
| alu_carry_i | input | 1 | ALU carry out |
| alu_ovf_i | input | 1 | ALU overflow |
| cmp_valid_i | input | 1 | Compare request |
| cmp_src_i | input | ACC_W | Compare operand |
| psf_we_i | input | 1 | Status flag write |
| psf_wdata_i | input | 5 | Status flag write data |
| flags_o | output | 7 | Status flags |

## Verification
The read ports are combinational, so the value an index selects is checked in the same cycle that index is driven. Everything that a clock edge updates must be visible one cycle after the stimulus. That covers entry contents, the pointer, the control fields, carry, equal, overflow and the general flags. Zero and sign follow combinationally in that same next cycle. The bench drives inputs just after a falling edge. At the next rising edge it advances a behavioural model that uses the values from before the edge. At the following falling edge it compares every output against that model, so each result is sampled exactly one edge after its cause.

// File: rtl/acc_file_pkg.sv
`timescale 1ns/1ps
package acc_file_pkg;

  typedef enum logic [1:0] {
    STEP_OFF  = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_NONE = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    GRP_2   = 2'b00,
    GRP_4   = 2'b01,
    GRP_8   = 2'b10,
    GRP_ALL = 2'b11
  } grp_e;

  typedef struct packed {
    logic gf1;
    logic gf0;
    logic ov;
    logic eq;
    logic sgn;
    logic zero;
    logic cy;
  } flags_t;

  localparam int CTL_W  = 5;
  localparam int PSFW_W = 5;

endpackage

// File: rtl/acc_regfile.sv
`timescale 1ns/1ps
module acc_regfile #(
  parameter int N  = 16,
  parameter int W  = 16,
  parameter int PW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [PW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [PW-1:0] ra_idx_i,
  output logic [W-1:0]  ra_data_o,
  input  logic [PW-1:0] rb_idx_i,
  output logic [W-1:0]  rb_data_o
);

  logic [W-1:0] ent [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && (widx_i == PW'(i)))  q <= wdata_i;
    end
    assign ent[i] = q;
  end

  assign ra_data_o = ent[ra_idx_i];
  assign rb_data_o = ent[rb_idx_i];

endmodule

// File: rtl/acc_ptr_ctrl.sv
`timescale 1ns/1ps
module acc_ptr_ctrl
  import acc_file_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [PW-1:0]    ptr_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             access_i,
  output logic [PW-1:0]    ptr_o,
  output logic [3:0]       ctl_o
);

  logic [PW-1:0] ptr_q, ptr_d;
  step_e         step_q;
  grp_e          grp_q;
  logic [PW-1:0] wrap_mask, cand, stepped;
  logic          step_en;

  // low bits that wrap inside the selected group
  always_comb begin
    unique case (grp_q)
      GRP_2:   wrap_mask = PW'(1);
      GRP_4:   wrap_mask = PW'(3);
      GRP_8:   wrap_mask = PW'(7);
      default: wrap_mask = '1;
    endcase
  end

  assign step_en = (step_q == STEP_UP) || (step_q == STEP_DOWN);
  assign cand    = (step_q == STEP_DOWN) ? ptr_q - PW'(1) : ptr_q + PW'(1);
  assign stepped = (ptr_q & ~wrap_mask) | (cand & wrap_mask);

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we_i)                         ptr_d = ptr_wdata_i;
    else if (ctl_we_i && ctl_wdata_i[0])  ptr_d = '0;
    else if (access_i && step_en)         ptr_d = stepped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      step_q <= STEP_OFF;
      grp_q  <= GRP_2;
    end else begin
      ptr_q <= ptr_d;
      if (ctl_we_i) begin
        step_q <= step_e'(ctl_wdata_i[2:1]);
        grp_q  <= grp_e'(ctl_wdata_i[4:3]);
      end
    end
  end

  assign ptr_o = ptr_q;
  assign ctl_o = {grp_q, step_q};

endmodule

// File: rtl/acc_flags.sv
`timescale 1ns/1ps
module acc_flags
  import acc_file_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      act_val_i,
  input  logic              cmp_valid_i,
  input  logic [W-1:0]      cmp_src_i,
  input  logic              arith_wr_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  input  logic              psf_we_i,
  input  logic [PSFW_W-1:0] psf_wdata_i,
  output flags_t            flags_o
);

  logic cy_q, eq_q, ov_q, gf0_q, gf1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cy_q  <= 1'b0;
      eq_q  <= 1'b0;
      ov_q  <= 1'b0;
      gf0_q <= 1'b0;
      gf1_q <= 1'b0;
    end else if (psf_we_i) begin
      cy_q  <= psf_wdata_i[0];
      eq_q  <= psf_wdata_i[1];
      ov_q  <= psf_wdata_i[2];
      gf0_q <= psf_wdata_i[3];
      gf1_q <= psf_wdata_i[4];
    end else begin
      if (arith_wr_i) begin
        cy_q <= alu_carry_i;
        ov_q <= alu_ovf_i;
      end
      if (cmp_valid_i) eq_q <= (act_val_i == cmp_src_i);
    end
  end

  // zero and sign are derived from whichever entry is active
  always_comb begin
    flags_o.cy   = cy_q;
    flags_o.zero = (act_val_i == '0);
    flags_o.sgn  = act_val_i[W-1];
    flags_o.eq   = eq_q;
    flags_o.ov   = ov_q;
    flags_o.gf0  = gf0_q;
    flags_o.gf1  = gf1_q;
  end

endmodule

// File: rtl/acc_file_top.sv
`timescale 1ns/1ps
module acc_file_top
  import acc_file_pkg::*;
#(
  parameter int NUM_ACC = 16,
  parameter int ACC_W   = 16,
  parameter int PW      = $clog2(NUM_ACC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PW-1:0]     dir_idx_i,
  input  logic              dir_we_i,
  input  logic [ACC_W-1:0]  dir_wdata_i,
  output logic [ACC_W-1:0]  dir_rdata_o,
  input  logic              act_re_i,
  input  logic              act_we_i,
  input  logic [ACC_W-1:0]  act_wdata_i,
  output logic [ACC_W-1:0]  act_rdata_o,
  input  logic              ptr_we_i,
  input  logic [PW-1:0]     ptr_wdata_i,
  output logic [PW-1:0]     ptr_o,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [3:0]        ctl_o,
  input  logic              alu_we_i,
  input  logic              alu_arith_i,
  input  logic [ACC_W-1:0]  alu_result_i,
  input  logic              alu_carry_i,
  input  logic              alu_ovf_i,
  input  logic              cmp_valid_i,
  input  logic [ACC_W-1:0]  cmp_src_i,
  input  logic              psf_we_i,
  input  logic [PSFW_W-1:0] psf_wdata_i,
  output logic [6:0]        flags_o
);

  logic             access;
  logic             wr_en;
  logic [PW-1:0]    wr_idx;
  logic [ACC_W-1:0] wr_data;
  logic [PW-1:0]    ptr;
  flags_t           flags;

  assign access = act_re_i | act_we_i | alu_we_i;

  // single write port: ALU, then active port, then direct port
  always_comb begin
    wr_en   = dir_we_i;
    wr_idx  = dir_idx_i;
    wr_data = dir_wdata_i;
    if (alu_we_i) begin
      wr_en   = 1'b1;
      wr_idx  = ptr;
      wr_data = alu_result_i;
    end else if (act_we_i) begin
      wr_en   = 1'b1;
      wr_idx  = ptr;
      wr_data = act_wdata_i;
    end
  end

  acc_regfile #(.N(NUM_ACC), .W(ACC_W), .PW(PW)) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .widx_i   (wr_idx),
    .wdata_i  (wr_data),
    .ra_idx_i (ptr),
    .ra_data_o(act_rdata_o),
    .rb_idx_i (dir_idx_i),
    .rb_data_o(dir_rdata_o)
  );

  acc_ptr_ctrl #(.PW(PW)) i_ptr_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_we_i   (ptr_we_i),
    .ptr_wdata_i(ptr_wdata_i),
    .ctl_we_i   (ctl_we_i),
    .ctl_wdata_i(ctl_wdata_i),
    .access_i   (access),
    .ptr_o      (ptr),
    .ctl_o      (ctl_o)
  );

  acc_flags #(.W(ACC_W)) i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_val_i  (act_rdata_o),
    .cmp_valid_i(cmp_valid_i),
    .cmp_src_i  (cmp_src_i),
    .arith_wr_i (alu_we_i & alu_arith_i),
    .alu_carry_i(alu_carry_i),
    .alu_ovf_i  (alu_ovf_i),
    .psf_we_i   (psf_we_i),
    .psf_wdata_i(psf_wdata_i),
    .flags_o    (flags)
  );

  assign ptr_o   = ptr;
  assign flags_o = flags;

endmodule

// File: rtl/acc_file_chk.sv
`timescale 1ns/1ps
module acc_file_chk #(
  parameter int PW = 4,
  parameter int W  = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ptr_we_i,
  input logic [PW-1:0] ptr_wdata_i,
  input logic [PW-1:0] ptr_o,
  input logic          ctl_we_i,
  input logic          ctl_clr_i,
  input logic          act_re_i,
  input logic          act_we_i,
  input logic          alu_we_i,
  input logic          alu_arith_i,
  input logic [W-1:0]  alu_result_i,
  input logic          cmp_valid_i,
  input logic [W-1:0]  cmp_src_i,
  input logic          psf_we_i,
  input logic [W-1:0]  act_rdata_o,
  input logic [6:0]    flags_o
);

  // R4
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_we_i |=> ptr_o == $past(ptr_wdata_i));

  // R5
  ptr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && ctl_clr_i && !ptr_we_i) |=> ptr_o == '0);

  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ptr_we_i && !(ctl_we_i && ctl_clr_i) && !act_re_i && !act_we_i && !alu_we_i)
      |=> $stable(ptr_o));

  // R3
  alu_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_we_i && ptr_we_i && ptr_wdata_i == ptr_o) |=> act_rdata_o == $past(alu_result_i));

  // R7
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[1] == (act_rdata_o == '0));

  // R8
  eq_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_i && !psf_we_i) |=> flags_o[3] == ($past(act_rdata_o) == $past(cmp_src_i)));

  // R9
  cy_ov_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!psf_we_i && !(alu_we_i && alu_arith_i)) |=> $stable(flags_o[0]) && $stable(flags_o[4]));

  // R10
  gf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psf_we_i |=> $stable(flags_o[6:5]));

endmodule

bind acc_file_top acc_file_chk #(.PW(PW), .W(ACC_W)) i_acc_file_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ptr_we_i    (ptr_we_i),
  .ptr_wdata_i (ptr_wdata_i),
  .ptr_o       (ptr_o),
  .ctl_we_i    (ctl_we_i),
  .ctl_clr_i   (ctl_wdata_i[0]),
  .act_re_i    (act_re_i),
  .act_we_i    (act_we_i),
  .alu_we_i    (alu_we_i),
  .alu_arith_i (alu_arith_i),
  .alu_result_i(alu_result_i),
  .cmp_valid_i (cmp_valid_i),
  .cmp_src_i   (cmp_src_i),
  .psf_we_i    (psf_we_i),
  .act_rdata_o (act_rdata_o),
  .flags_o     (flags_o)
);

// File: tb/test_acc_file_top.sv
`timescale 1ns/1ps
module test_acc_file_top;
  localparam int N  = 16;
  localparam int W  = 16;
  localparam int PW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [PW-1:0] dir_idx;
  logic          dir_we;
  logic [W-1:0]  dir_wdata, dir_rdata;
  logic          act_re, act_we;
  logic [W-1:0]  act_wdata, act_rdata;
  logic          ptr_we;
  logic [PW-1:0] ptr_wdata, ptr;
  logic          ctl_we;
  logic [4:0]    ctl_wdata;
  logic [3:0]    ctl;
  logic          alu_we, alu_arith, alu_carry, alu_ovf;
  logic [W-1:0]  alu_result;
  logic          cmp_valid;
  logic [W-1:0]  cmp_src;
  logic          psf_we;
  logic [4:0]    psf_wdata;
  logic [6:0]    flags;

  acc_file_top #(.NUM_ACC(N), .ACC_W(W)) i_acc_file_top (
    .clk_i(clk), .rst_ni(rst_n),
    .dir_idx_i(dir_idx), .dir_we_i(dir_we), .dir_wdata_i(dir_wdata), .dir_rdata_o(dir_rdata),
    .act_re_i(act_re), .act_we_i(act_we), .act_wdata_i(act_wdata), .act_rdata_o(act_rdata),
    .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata), .ptr_o(ptr),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_o(ctl),
    .alu_we_i(alu_we), .alu_arith_i(alu_arith), .alu_result_i(alu_result),
    .alu_carry_i(alu_carry), .alu_ovf_i(alu_ovf),
    .cmp_valid_i(cmp_valid), .cmp_src_i(cmp_src),
    .psf_we_i(psf_we), .psf_wdata_i(psf_wdata), .flags_o(flags)
  );

  int n_chk = 0;
  int n_err = 0;

  // behavioural reference state
  int m_acc[N];
  int m_ptr, m_step, m_grp;
  bit m_c, m_e, m_ov, m_g0, m_g1;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int grp_size(int g);
    case (g)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return N;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_acc[i] = 0;
    m_ptr = 0; m_step = 0; m_grp = 0;
    m_c = 0; m_e = 0; m_ov = 0; m_g0 = 0; m_g1 = 0;
  endtask

  task automatic model_edge();
    int old_act = m_acc[m_ptr];
    bit touch = act_re | act_we | alu_we;
    if (psf_we) begin
      m_c = psf_wdata[0]; m_e = psf_wdata[1]; m_ov = psf_wdata[2];
      m_g0 = psf_wdata[3]; m_g1 = psf_wdata[4];
    end else begin
      if (alu_we && alu_arith) begin m_c = alu_carry; m_ov = alu_ovf; end
      if (cmp_valid) m_e = (old_act == int'(cmp_src));
    end
    if (alu_we)      m_acc[m_ptr] = int'(alu_result);
    else if (act_we) m_acc[m_ptr] = int'(act_wdata);
    else if (dir_we) m_acc[int'(dir_idx)] = int'(dir_wdata);
    if (ptr_we) m_ptr = int'(ptr_wdata);
    else if (ctl_we && ctl_wdata[0]) m_ptr = 0;
    else if (touch && (m_step == 1 || m_step == 2)) begin
      int g = grp_size(m_grp);
      int base = (m_ptr / g) * g;
      int off = m_ptr % g;
      off = (m_step == 1) ? (off + 1) % g : (off + g - 1) % g;
      m_ptr = base + off;
    end
    if (ctl_we) begin m_step = int'(ctl_wdata[2:1]); m_grp = int'(ctl_wdata[4:3]); end
  endtask

  task automatic compare_all();
    int a = m_acc[m_ptr];
    logic [6:0] ef;
    ef = {m_g1, m_g0, m_ov, m_e, a[W-1], (a == 0), m_c};
    chk("R6 ptr", 32'(ptr), 32'(m_ptr));
    chk("R5 ctl", 32'(ctl), 32'({m_grp[1:0], m_step[1:0]}));
    chk("R2 act", 32'(act_rdata), 32'(a));
    chk("R1 dir", 32'(dir_rdata), 32'(m_acc[int'(dir_idx)]));
    chk("R7 flags", 32'(flags), 32'(ef));
  endtask

  task automatic idle();
    dir_we = 0; act_re = 0; act_we = 0; ptr_we = 0; ctl_we = 0;
    alu_we = 0; alu_arith = 0; alu_carry = 0; alu_ovf = 0;
    cmp_valid = 0; psf_we = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic set_ptr(int p);
    ptr_we = 1; ptr_wdata = PW'(p); tick();
  endtask

  task automatic set_ctl(logic [4:0] v);
    ctl_we = 1; ctl_wdata = v; tick();
  endtask

  initial begin
    rst_n = 0; idle();
    dir_idx = '0; dir_wdata = '0; act_wdata = '0; ptr_wdata = '0; ctl_wdata = '0;
    alu_result = '0; cmp_src = '0; psf_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ptr", 32'(ptr), 0);
    chk("R11 flags", 32'(flags), 32'h02);
    chk("R11 act", 32'(act_rdata), 0);
    chk("R11 ctl", 32'(ctl), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 direct fill
    for (int k = 0; k < N; k++) begin
      dir_we = 1; dir_idx = PW'(k); dir_wdata = W'(k * 37 + 3); tick();
    end
    dir_idx = 4'd9; #1;
    chk("R1 direct read", 32'(dir_rdata), 32'd336);

    // R4 / R2
    set_ptr(5);
    chk("R4 ptr load", 32'(ptr), 5);
    chk("R2 active read", 32'(act_rdata), 32'd188);

    // R7 zero and sign
    act_we = 1; act_wdata = 16'h0000; tick();
    chk("R7 zero set", 32'(flags[1]), 1);
    act_we = 1; act_wdata = 16'h8001; tick();
    chk("R7 sign set", 32'(flags[2:1]), 32'b10);
    set_ptr(9);
    chk("R7 zero after move", 32'(flags[2:1]), 32'b00);

    // R6 full-file up wrap 15 -> 0
    set_ctl(5'b11010);
    set_ptr(15);
    act_re = 1; tick();
    chk("R6 full wrap", 32'(ptr), 0);
    // group of 4, up: 7 -> 4
    set_ctl(5'b01010);
    set_ptr(7);
    act_re = 1; tick();
    chk("R6 group4 wrap", 32'(ptr), 4);
    // group of 2, down: 10 -> 11
    set_ctl(5'b00100);
    set_ptr(10);
    act_we = 1; act_wdata = 16'h00aa; tick();
    chk("R6 group2 down", 32'(ptr), 11);
    // group of 8, down: 8 -> 15
    set_ctl(5'b10100);
    set_ptr(8);
    alu_we = 1; alu_result = 16'h0042; tick();
    chk("R6 group8 down", 32'(ptr), 15);
    for (int k = 0; k < 20; k++) begin act_re = 1; tick(); end

    // R5 clear beats step, R4 load beats clear
    set_ptr(6);
    ctl_we = 1; ctl_wdata = 5'b00001; act_re = 1; tick();
    chk("R5 clear", 32'(ptr), 0);
    chk("R5 ctl readback", 32'(ctl), 0);
    ctl_we = 1; ctl_wdata = 5'b00001; ptr_we = 1; ptr_wdata = 4'd6; tick();
    chk("R4 load over clear", 32'(ptr), 6);

    // R3 write priority, R9 arithmetic flags
    set_ptr(3);
    alu_we = 1; alu_arith = 1; alu_result = 16'h1234; alu_carry = 1; alu_ovf = 1;
    act_we = 1; act_wdata = 16'h5555; dir_we = 1; dir_idx = 4'd3; dir_wdata = 16'h7777;
    tick();
    chk("R3 alu wins", 32'(act_rdata), 32'h1234);
    chk("R9 carry ov", 32'({flags[4], flags[0]}), 32'b11);
    alu_we = 1; alu_arith = 0; alu_result = 16'h0000; tick();
    chk("R9 logic op keeps carry", 32'({flags[4], flags[0]}), 32'b11);

    // R8 equal
    cmp_valid = 1; cmp_src = 16'h0000; tick();
    chk("R8 equal hit", 32'(flags[3]), 1);
    cmp_valid = 1; cmp_src = 16'h0005; tick();
    chk("R8 equal miss", 32'(flags[3]), 0);

    // R10 status write over hardware update
    psf_we = 1; psf_wdata = 5'b11000;
    alu_we = 1; alu_arith = 1; alu_result = 16'h0001; alu_carry = 1; alu_ovf = 1;
    tick();
    chk("R10 psf write", 32'(flags), 32'b1100000);

    // mixed stimulus against the model
    for (int k = 0; k < 400; k++) begin
      dir_idx = PW'($urandom);
      dir_we = ($urandom % 4) == 0; dir_wdata = W'($urandom % 3 == 0 ? 0 : $urandom);
      act_re = ($urandom % 3) == 0;
      act_we = ($urandom % 5) == 0; act_wdata = W'($urandom);
      ptr_we = ($urandom % 9) == 0; ptr_wdata = PW'($urandom);
      ctl_we = ($urandom % 11) == 0; ctl_wdata = 5'($urandom);
      alu_we = ($urandom % 5) == 0; alu_arith = $urandom; alu_result = W'($urandom);
      alu_carry = $urandom; alu_ovf = $urandom;
      cmp_valid = ($urandom % 4) == 0; cmp_src = W'($urandom % 2 == 0 ? 0 : $urandom);
      psf_we = ($urandom % 13) == 0; psf_wdata = 5'($urandom);
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule